// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. A start pulse captures a starting column together with the 12-bit mode register word. The burst fields of that word set how many beats follow and in what order their addresses are visited.

Short bursts of 2, 4 or 8 beats wrap inside an aligned block of their own size. The ordering within the block is either sequential, where the low bits count up, or interleaved, where the low bits are the start column XORed with the beat number. A full-page burst counts through all 256 columns and keeps wrapping until a stop pulse ends it. A write-mode bit in the mode word can cut writes down to a single beat. Reserved burst-length or latency codes raise an error flag, and while that flag is high no burst can start.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and whenever no burst is active, `busy_o` and `last_o` are 0 and `col_o` is 0.
- R2: Burst-length field `mode_i[2:0]` values 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `busy_o` stays high for exactly that many cycles, and `last_o` is high only on the final beat.
- R3: With `mode_i[3]`=0 (sequential), beat b has column `(S & ~M) | ((S+b) & M)`, where S is the start column and M = length-1.
- R4: With `mode_i[3]`=1 (interleave), beat b has column `(S & ~M) | ((S^b) & M)`.
- R5: Length code 111 with `mode_i[3]`=0 is a full-page burst. Beat b has column `(S+b) mod 256`, the burst continues past 256 beats, and `last_o` never rises.
- R6: If `mode_i[9]`=1 and `write_i`=1 at start, the burst has one beat. If `mode_i[9]`=1 and the access is a read, or if `mode_i[9]`=0 and the access is a write, the burst has the programmed length.
- R7: `err_o` is high in the same cycle when the length field is 100, 101 or 110, when it is 111 with `mode_i[3]`=1, or when the latency field `mode_i[6:4]` is anything other than 010 or 011.
- R8: A start pulse while `err_o` is high is ignored. An idle generator stays idle, and a running burst continues unchanged.
- R9: A stop pulse ends the running burst. `busy_o` is low from the next cycle on.
- R10: A valid start pulse during a running burst begins the new burst on the next cycle at beat 0, and it wins over a stop pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a burst this cycle |
| start_col_i | input | 8 | Starting column |
| mode_i | input | 12 | Mode register word |
| write_i | input | 1 | Access is a write |
| stop_i | input | 1 | End the running burst |
| col_o | output | 8 | Column address of the current beat |
| busy_o | output | 1 | Burst active |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Mode word holds a reserved code |

## Verification
`err_o` depends only on `mode_i` and is valid in the same cycle, so the bench changes the mode word and checks the flag after a short settle delay, without a clock edge in between. The start column is captured on the edge where `start_i` is high. Beat 0 therefore appears on the outputs in the very next cycle, and beat b appears b cycles after that. The bench drives inputs on falling edges and compares beat b on the falling edge b+1 cycles after the start. A stop pulse is checked one cycle after it is applied, and so is a start that should have been ignored.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W  = 8,
  parameter int MR_W   = 12,
  parameter int BL_LSB = 0,
  parameter int BT_BIT = 3,
  parameter int CL_LSB = 4,
  parameter int WM_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [MR_W-1:0]  mode_i,
  input  logic             write_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             err_o
);
  localparam logic [COL_W-1:0] ALL1 = {COL_W{1'b1}};

  logic [2:0] bl_code, cl_code;
  logic       il_sel, wr_single, go;
  logic       bad_bl, bad_cl;
  logic [COL_W-1:0] new_mask;
  logic             new_full;

  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic             seq_q, full_q, busy_q;
  logic [COL_W-1:0] low_bits;

  assign bl_code   = mode_i[BL_LSB +: 3];
  assign cl_code   = mode_i[CL_LSB +: 3];
  assign il_sel    = mode_i[BT_BIT];
  assign wr_single = write_i & mode_i[WM_BIT];

  assign bad_bl = (bl_code[2] & (bl_code[1:0] != 2'b11)) | ((bl_code == 3'b111) & il_sel);
  assign bad_cl = (cl_code != 3'b010) & (cl_code != 3'b011);
  assign err_o  = bad_bl | bad_cl;
  assign go     = start_i & ~err_o;

  always_comb begin
    new_full = 1'b0;
    case (bl_code)
      3'b001:  new_mask = COL_W'(1);
      3'b010:  new_mask = COL_W'(3);
      3'b011:  new_mask = COL_W'(7);
      3'b111:  begin new_mask = ALL1; new_full = 1'b1; end
      default: new_mask = '0;
    endcase
    if (wr_single) begin
      new_mask = '0;
      new_full = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      seq_q  <= 1'b1;
      full_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= start_col_i;
      mask_q <= new_mask;
      seq_q  <= ~il_sel;
      full_q <= new_full;
    end else if (busy_q) begin
      if (stop_i || last_o) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign low_bits = seq_q ? (base_q + cnt_q) : (base_q ^ cnt_q);
  assign col_o    = busy_q ? ((base_q & ~mask_q) | (low_bits & mask_q)) : '0;
  assign busy_o   = busy_q;
  assign last_o   = busy_q & ~full_q & (cnt_q == mask_q);
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             busy_o,
  input logic             last_o,
  input logic             err_o
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (col_o == '0) && !last_o);

  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !(start_i && !err_o) |=> !busy_o);

  a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && err_o |=> !busy_o);

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !(start_i && !err_o) |=> !busy_o);

  a_r10_start_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !err_o |=> busy_o && (col_o == $past(start_col_i)));
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
  .stop_i(stop_i), .col_o(col_o), .busy_o(busy_o), .last_o(last_o), .err_o(err_o)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [11:0] mode_i = '0;
  logic write_i = 1'b0;
  logic stop_i = 1'b0;
  logic [7:0] col_o;
  logic busy_o, last_o, err_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .mode_i(mode_i), .write_i(write_i), .stop_i(stop_i),
    .col_o(col_o), .busy_o(busy_o), .last_o(last_o), .err_o(err_o)
  );

  function automatic logic [11:0] mk(input bit wm, input bit il, input logic [2:0] bl);
    return {2'b00, wm, 2'b00, 3'b011, il, bl};
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int b, input int n, input bit il);
    logic [7:0] m, lo;
    m  = 8'(n - 1);
    lo = il ? (s ^ 8'(b)) : 8'(int'(s) + b);
    return (s & ~m) | (lo & m);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic kick(input logic [7:0] c, input logic [11:0] m, input bit wr);
    start_col_i = c; mode_i = m; write_i = wr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; write_i = 1'b0;
  endtask

  task automatic run(input string req, input logic [7:0] c, input logic [11:0] m,
                     input bit wr, input int n, input bit il);
    kick(c, m, wr);
    for (int b = 0; b < n; b++) begin
      chk({req, " busy"}, busy_o, 1);
      chk({req, " col"}, col_o, exp_col(c, b, n, il));
      chk({req, " last"}, last_o, (b == n - 1));
      @(negedge clk);
    end
    chk({req, " end"}, busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    mode_i = mk(0, 0, 3'b011);
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 last", last_o, 0);
    chk("R1 col", col_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4096; m++) begin
      logic [11:0] mv;
      bit e;
      mv = 12'(m);
      mode_i = mv;
      #1;
      e = (mv[2] && mv[1:0] != 2'b11) || (mv[2:0] == 3'b111 && mv[3]) ||
          !(mv[6:4] == 3'b010 || mv[6:4] == 3'b011);
      chk("R7 err", err_o, e);
    end
    @(negedge clk);

    for (int il = 0; il < 2; il++)
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 256; c++)
          run(il ? "R4 R2" : "R3 R2", 8'(c), mk(0, il[0], 3'(k)), 0, 1 << k, il[0]);

    for (int c = 0; c < 256; c += 37) begin
      kick(8'(c), mk(0, 0, 3'b111), 0);
      for (int b = 0; b < 300; b++) begin
        chk("R5 busy", busy_o, 1);
        chk("R5 col", col_o, (c + b) % 256);
        chk("R5 last", last_o, 0);
        @(negedge clk);
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R9 stop", busy_o, 0);
      chk("R9 col", col_o, 0);
    end

    run("R6 wr single", 8'h35, mk(1, 0, 3'b011), 1, 1, 0);
    run("R6 wr single fp", 8'h35, mk(1, 0, 3'b111), 1, 1, 0);
    run("R6 rd burst", 8'h35, mk(1, 1, 3'b011), 0, 8, 1);
    run("R6 wr burst", 8'h35, mk(0, 0, 3'b010), 1, 4, 0);

    kick(8'h40, {2'b00, 1'b0, 2'b00, 3'b111, 1'b0, 3'b011}, 0);
    chk("R8 idle", busy_o, 0);
    kick(8'h40, mk(0, 1, 3'b111), 0);
    chk("R8 il fp", busy_o, 0);

    kick(8'h13, mk(0, 0, 3'b011), 0);
    chk("R8 b0", col_o, 8'h13);
    @(negedge clk);
    kick(8'h77, mk(0, 0, 3'b101), 0);
    for (int b = 2; b < 8; b++) begin
      chk("R8 continue", col_o, exp_col(8'h13, b, 8, 0));
      @(negedge clk);
    end
    chk("R8 end", busy_o, 0);

    kick(8'h10, mk(0, 0, 3'b011), 0);
    @(negedge clk); @(negedge clk);
    stop_i = 1'b1;
    kick(8'h25, mk(0, 1, 3'b010), 0);
    stop_i = 1'b0;
    for (int b = 0; b < 4; b++) begin
      chk("R10 col", col_o, exp_col(8'h25, b, 4, 1));
      chk("R10 last", last_o, (b == 3));
      @(negedge clk);
    end
    chk("R10 end", busy_o, 0);

    kick(8'h50, mk(0, 0, 3'b010), 0);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R9 early stop", busy_o, 0);
    chk("R1 last idle", last_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule